// File: doc/BRIEF.md
# Kernel Cache Maintenance Tracker

This block follows the cache upkeep that surrounds one kernel run. Before the kernel starts, a dispatcher issues cache invalidations and reports each batch, and each returning acknowledgement, to the tracker as a signed change in the pending count. After the kernel finishes, the same is done for cache writebacks. The tracker tells the dispatcher whether invalidation has begun, whether it has drained, and how many requests of each kind are still outstanding. Issuing the memory requests themselves happens elsewhere.

Invalidation has three states: idle (nothing issued yet), active with a pending count, and drained (active with a count of zero). Hardware keeps this as an "active" flag beside an unsigned count instead of a signed sentinel value. A force-drain command jumps straight to the drained state without counting. The writeback side is a plain non-negative counter. Misuse (a count pushed out of range, or asking whether invalidation is drained while it is still idle) raises an error flag that stays up until reset. All pins are plain control and status lines: each update is a single-cycle strobe with no back-pressure, every strobe is accepted on the clock edge that samples it, and all outputs are registered state visible from the following cycle.

Top module: `kcm_tracker`

## Requirements
- R1: After reset, inv_active, inv_drained, wb_zero... are as follows: inv_active=0, inv_drained=0, inv_pending=0, wb_pending=0, wb_zero=1, fault=0.
- R2: While idle, an invalidation update with a positive delta makes inv_active 1 and loads inv_pending with the delta itself (not delta minus one) on the next cycle.
- R3: While active, an invalidation update adds its signed delta to inv_pending; inv_drained is 1 exactly when the tracker is active and inv_pending is 0.
- R4: An invalidation update whose result would fall below 0 or above 65535 is discarded (inv_pending unchanged) and sets fault.
- R5: inv_force_drain makes the tracker active with inv_pending 0 on the next cycle; an invalidation update in the same cycle is dropped without effect or fault.
- R6: A strobe on inv_drain_query while idle sets fault; the same query while active leaves fault at 0.
- R7: While idle, a zero delta leaves the tracker idle without fault; a negative delta leaves it idle and sets fault.
- R8: A writeback update adds its signed delta to wb_pending; wb_zero is 1 exactly when wb_pending is 0.
- R9: A writeback update whose result would fall below 0 or above 65535 is discarded (wb_pending unchanged) and sets fault.
- R10: Once set, fault stays 1 until reset while later valid updates still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_upd | input | 1 | Invalidation update strobe |
| inv_delta | input | 16 | Signed two's-complement change to the invalidation count |
| inv_force_drain | input | 1 | Force invalidation to the drained state |
| inv_drain_query | input | 1 | Strobe marking that the dispatcher reads inv_drained this cycle |
| wb_upd | input | 1 | Writeback update strobe |
| wb_delta | input | 16 | Signed two's-complement change to the writeback count |
| inv_active | output | 1 | Invalidation has begun |
| inv_drained | output | 1 | Invalidation active with nothing pending |
| inv_pending | output | 16 | Outstanding invalidations |
| wb_pending | output | 16 | Outstanding writebacks |
| wb_zero | output | 1 | No writebacks outstanding |
| fault | output | 1 | Sticky misuse flag |

## Verification
Invalidation is driven with a first positive load from idle, growing and shrinking deltas that land on zero, deltas that would underflow or overflow, and zero or negative deltas while idle; these separate a load from an add onto a sentinel, and a discarded update from a clamped one. Force-drain is tried alone and colliding with an update, which tells priority apart from summation. Writeback is driven up, down to zero and below zero. Drain queries are issued while idle and while active, and fault is watched across idle cycles and later valid updates to show it is sticky without blocking the counters.

// File: rtl/kcm_pkg.sv
package kcm_pkg;
  localparam int CNT_W = 16;
  localparam int GUARD = 2;
  localparam int NUM_FAULT_SRC = 2;
endpackage

// File: rtl/kcm_inv_tracker.sv
module kcm_inv_tracker #(
  parameter int W = kcm_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [W-1:0] delta,
  input  logic         force_drain,
  input  logic         query,
  output logic         active,
  output logic         drained,
  output logic [W-1:0] pending,
  output logic         viol
);
  localparam int SW = W + kcm_pkg::GUARD;

  logic         act_q, act_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic signed [SW-1:0] sum;
  logic out_of_range, d_neg, d_pos, upd_bad;

  assign sum = $signed({{kcm_pkg::GUARD{1'b0}}, cnt_q})
             + $signed({{kcm_pkg::GUARD{delta[W-1]}}, delta});
  assign out_of_range = sum[SW-1] | sum[SW-2];
  assign d_neg = delta[W-1];
  assign d_pos = ~delta[W-1] & (|delta);

  always_comb begin
    act_d   = act_q;
    cnt_d   = cnt_q;
    upd_bad = 1'b0;
    if (force_drain) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (upd) begin
      if (act_q) begin
        if (out_of_range) upd_bad = 1'b1;
        else              cnt_d   = sum[W-1:0];
      end else if (d_neg) begin
        upd_bad = 1'b1;
      end else if (d_pos) begin
        act_d = 1'b1;
        cnt_d = delta;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign active  = act_q;
  assign drained = act_q & (cnt_q == '0);
  assign pending = cnt_q;
  assign viol    = upd_bad | (query & ~act_q);

  assert_force_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    force_drain |=> (active && pending == '0));

  assert_first_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !force_drain && !active && d_pos) |=> (active && pending == W'($past(delta))));

  assert_active_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> active);

  assert_reject_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !force_drain && active && out_of_range) |=> $stable(pending));

  assert_idle_query_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (query && !active) |-> viol);
endmodule

// File: rtl/kcm_wb_tracker.sv
module kcm_wb_tracker #(
  parameter int W = kcm_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [W-1:0] delta,
  output logic [W-1:0] pending,
  output logic         zero,
  output logic         viol
);
  localparam int SW = W + kcm_pkg::GUARD;

  logic [W-1:0] cnt_q;
  logic signed [SW-1:0] sum;
  logic bad;

  assign sum = $signed({{kcm_pkg::GUARD{1'b0}}, cnt_q})
             + $signed({{kcm_pkg::GUARD{delta[W-1]}}, delta});
  assign bad = upd & (sum[SW-1] | sum[SW-2]);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (upd && !bad) cnt_q <= sum[W-1:0];
  end

  assign pending = cnt_q;
  assign zero    = (cnt_q == '0);
  assign viol    = bad;

  assert_wb_reject_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> $stable(pending));

  assert_wb_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(pending));
endmodule

// File: rtl/kcm_sticky_flag.sv
module kcm_sticky_flag #(
  parameter int N = kcm_pkg::NUM_FAULT_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  output logic         flag
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (|set)  flag_q <= 1'b1;
  end

  assign flag = flag_q;

  assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flag |=> flag);

  assert_fault_raised_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> flag);
endmodule

// File: rtl/kcm_tracker.sv
module kcm_tracker #(
  parameter int CNT_W = kcm_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_upd,
  input  logic [CNT_W-1:0] inv_delta,
  input  logic             inv_force_drain,
  input  logic             inv_drain_query,
  input  logic             wb_upd,
  input  logic [CNT_W-1:0] wb_delta,
  output logic             inv_active,
  output logic             inv_drained,
  output logic [CNT_W-1:0] inv_pending,
  output logic [CNT_W-1:0] wb_pending,
  output logic             wb_zero,
  output logic             fault
);
  logic inv_viol, wb_viol;

  kcm_inv_tracker #(.W(CNT_W)) inv_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd         (inv_upd),
    .delta       (inv_delta),
    .force_drain (inv_force_drain),
    .query       (inv_drain_query),
    .active      (inv_active),
    .drained     (inv_drained),
    .pending     (inv_pending),
    .viol        (inv_viol)
  );

  kcm_wb_tracker #(.W(CNT_W)) wb_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (wb_upd),
    .delta   (wb_delta),
    .pending (wb_pending),
    .zero    (wb_zero),
    .viol    (wb_viol)
  );

  kcm_sticky_flag #(.N(kcm_pkg::NUM_FAULT_SRC)) flt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .set   ({wb_viol, inv_viol}),
    .flag  (fault)
  );
endmodule

// File: tb/kcm_tracker_tb.sv
module kcm_tracker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inv_upd = 1'b0;
  logic [15:0] inv_delta = '0;
  logic        inv_force_drain = 1'b0;
  logic        inv_drain_query = 1'b0;
  logic        wb_upd = 1'b0;
  logic [15:0] wb_delta = '0;
  logic        inv_active, inv_drained, wb_zero, fault;
  logic [15:0] inv_pending, wb_pending;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  kcm_tracker dut_i (
    .clk(clk), .rst_n(rst_n),
    .inv_upd(inv_upd), .inv_delta(inv_delta),
    .inv_force_drain(inv_force_drain), .inv_drain_query(inv_drain_query),
    .wb_upd(wb_upd), .wb_delta(wb_delta),
    .inv_active(inv_active), .inv_drained(inv_drained),
    .inv_pending(inv_pending), .wb_pending(wb_pending),
    .wb_zero(wb_zero), .fault(fault)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one-cycle stimulus; returns at the negedge after the sampling edge
  task automatic drive(input bit iu, input int idl, input bit fd, input bit q,
                       input bit wu, input int wdl);
    @(negedge clk);
    inv_upd = iu; inv_delta = 16'(idl); inv_force_drain = fd;
    inv_drain_query = q; wb_upd = wu; wb_delta = 16'(wdl);
    @(negedge clk);
    inv_upd = 1'b0; inv_delta = '0; inv_force_drain = 1'b0;
    inv_drain_query = 1'b0; wb_upd = 1'b0; wb_delta = '0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 inv_active", inv_active, 0);
    chk("R1 inv_drained", inv_drained, 0);
    chk("R1 inv_pending", inv_pending, 0);
    chk("R1 wb_pending", wb_pending, 0);
    chk("R1 wb_zero", wb_zero, 1);
    chk("R1 fault", fault, 0);
  endtask

  task automatic t_first_load_R2();
    do_reset();
    drive(1, 5, 0, 0, 0, 0);
    chk("R2 active", inv_active, 1);
    chk("R2 pending", inv_pending, 5);
    chk("R2 drained", inv_drained, 0);
  endtask

  task automatic t_accumulate_R3();
    drive(1, 3, 0, 0, 0, 0);
    chk("R3 add", inv_pending, 8);
    drive(1, -8, 0, 1, 0, 0);
    chk("R3 to zero", inv_pending, 0);
    chk("R3 drained", inv_drained, 1);
    chk("R6 active query no fault", fault, 0);
    drive(1, 2, 0, 0, 0, 0);
    chk("R3 reopen", inv_drained, 0);
  endtask

  task automatic t_reject_R4();
    do_reset();
    drive(1, 2, 0, 0, 0, 0);
    drive(1, -3, 0, 0, 0, 0);
    chk("R4 underflow held", inv_pending, 2);
    chk("R4 underflow fault", fault, 1);
    do_reset();
    drive(1, 32767, 0, 0, 0, 0);
    drive(1, 32767, 0, 0, 0, 0);
    chk("R4 near top", inv_pending, 65534);
    chk("R4 no fault yet", fault, 0);
    drive(1, 2, 0, 0, 0, 0);
    chk("R4 overflow held", inv_pending, 65534);
    chk("R4 overflow fault", fault, 1);
  endtask

  task automatic t_force_R5();
    do_reset();
    drive(1, 9, 1, 0, 0, 0);
    chk("R5 active", inv_active, 1);
    chk("R5 pending", inv_pending, 0);
    chk("R5 drained", inv_drained, 1);
    chk("R5 no fault", fault, 0);
    drive(1, 4, 0, 0, 0, 0);
    drive(1, -10, 1, 0, 0, 0);
    chk("R5 mid force", inv_pending, 0);
    chk("R5 dropped update no fault", fault, 0);
  endtask

  task automatic t_query_R6();
    do_reset();
    drive(0, 0, 0, 1, 0, 0);
    chk("R6 idle query fault", fault, 1);
    do_reset();
    drive(1, 1, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 0, 0);
    chk("R6 active query clean", fault, 0);
  endtask

  task automatic t_idle_R7();
    do_reset();
    drive(1, 0, 0, 0, 0, 0);
    chk("R7 zero stays idle", inv_active, 0);
    chk("R7 zero no fault", fault, 0);
    drive(1, -1, 0, 0, 0, 0);
    chk("R7 neg stays idle", inv_active, 0);
    chk("R7 neg pending", inv_pending, 0);
    chk("R7 neg fault", fault, 1);
  endtask

  task automatic t_wb_R8();
    do_reset();
    drive(0, 0, 0, 0, 1, 10);
    chk("R8 up", wb_pending, 10);
    chk("R8 nonzero", wb_zero, 0);
    drive(0, 0, 0, 0, 1, -4);
    chk("R8 down", wb_pending, 6);
    drive(0, 0, 0, 0, 1, -6);
    chk("R8 zero count", wb_pending, 0);
    chk("R8 zero flag", wb_zero, 1);
    chk("R8 no fault", fault, 0);
  endtask

  task automatic t_wb_R9();
    do_reset();
    drive(0, 0, 0, 0, 1, -1);
    chk("R9 underflow held", wb_pending, 0);
    chk("R9 fault", fault, 1);
  endtask

  task automatic t_sticky_R10();
    do_reset();
    drive(0, 0, 0, 0, 1, -1);
    repeat (5) @(negedge clk);
    chk("R10 held", fault, 1);
    drive(0, 0, 0, 0, 1, 7);
    chk("R10 still counts", wb_pending, 7);
    chk("R10 still set", fault, 1);
    do_reset();
    chk("R10 cleared by reset", fault, 0);
  endtask

  initial begin
    t_reset();
    t_first_load_R2();
    t_accumulate_R3();
    t_reject_R4();
    t_force_R5();
    t_query_R6();
    t_idle_R7();
    t_wb_R8();
    t_wb_R9();
    t_sticky_R10();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule